// File: doc/BRIEF.md
# Fair Burst Memory Request Arbiter

This block shares one memory command port among a parameterised number of channels. Each channel has two request lines, one for read bursts and one for write bursts, and each line comes with a start address. The block sends each accepted request to the command port as a single burst command of fixed length, `BURST_LEN` words. Single-word accesses never occur. A channel keeps its request and address steady until it sees its grant pulse, and it drops the request on the next clock edge.

The read side and the write side each have their own round-robin pointer, so no channel can hold on to either direction. When both directions have work waiting, the block alternates between them. When only one direction has work, that direction is served back to back. A command stays on the port until it is accepted (`cmd_valid` and `cmd_ready` both high), and each accepted command produces exactly one grant pulse. Two saturating counters record how many cycles the port was occupied and how many it was empty, so the used share of bandwidth can be read out.

The channel count can be any value from 1 to 16. It does not need to be a power of two.

Top module: `burst_req_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cmd_valid` is 0, every grant bit is 0 and both counters are 0. This holds even when requests are raised.
- R2: Every command carries `cmd_len` equal to `BURST_LEN`. `cmd_addr` is the address slice of the chosen channel, where channel i uses bits [i*ADDR_W +: ADDR_W] of `rd_addr` or `wr_addr`. `cmd_chan` is the channel index.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, the next cycle keeps `cmd_valid` high and leaves `cmd_addr`, `cmd_chan` and `cmd_write` unchanged.
- R4: A grant is a one-hot pulse in the handshake cycle only. Bit `cmd_chan` is set in `rd_gnt` when `cmd_write` is 0, or in `wr_gnt` when `cmd_write` is 1. At most one grant bit is high in any cycle.
- R5: A read command goes to the first requesting channel at or after the channel that follows the last granted read channel, wrapping modulo `NUM_CH`.
- R6: Write commands follow the same rotation with their own pointer, which is independent of read grants.
- R7: When both read and write requests are pending at the time a command is chosen, its direction is the opposite of the last accepted command (`cmd_write` 1 means write).
- R8: When only one direction has pending requests, that direction is chosen, whatever the last direction was.
- R9: After a handshake, `cmd_valid` is 0 for exactly one cycle. A cycle with `cmd_valid` at 0 and any request pending is followed by a cycle with `cmd_valid` at 1.
- R10: `busy_cnt` counts cycles with `cmd_valid` high and `idle_cnt` counts cycles with it low. Each counter saturates at 2^CNT_W-1.
- R11: After reset both pointers start at channel 0. The first command, when both directions are pending, is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | NUM_CH | Read-burst request per channel |
| rd_addr | input | NUM_CH*ADDR_W | Read start addresses, one slice per channel |
| wr_req | input | NUM_CH | Write-burst request per channel |
| wr_addr | input | NUM_CH*ADDR_W | Write start addresses, one slice per channel |
| rd_gnt | output | NUM_CH | Read grant pulse, one-hot |
| wr_gnt | output | NUM_CH | Write grant pulse, one-hot |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Memory side accepts the command |
| cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| cmd_chan | output | CH_W | Channel that owns the command |
| cmd_addr | output | ADDR_W | Burst start address |
| cmd_len | output | LEN_W | Burst length in words |
| busy_cnt | output | CNT_W | Cycles with a command present, saturating |
| idle_cnt | output | CNT_W | Cycles without a command, saturating |

## Verification
The assertions assume that requesters behave well. A channel holds its request and its address slice unchanged from the moment it raises the request until its grant pulse. It lowers the request on the edge that ends the grant cycle and never keeps it high past a grant. The bench models every channel as such a requester: it clears a pending bit only after the clock edge that consumed the grant, and it loads new request masks only when nothing is outstanding. Stalls are produced only through `cmd_ready` patterns, which the design has to tolerate in any form.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    // Index width for a count, at least one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Direction choice: alternate when both sides wait, else the busy side.
    function automatic dir_e pick_dir(input logic rd_any, input logic wr_any, input dir_e last);
        if (rd_any && wr_any)
            return (last == DIR_RD) ? DIR_WR : DIR_RD;
        else if (wr_any)
            return DIR_WR;
        else
            return DIR_RD;
    endfunction

endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int NUM_CH = 5,
    localparam int CH_W = arb_pkg::idx_w(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    input  logic              adv,
    input  logic [CH_W-1:0]   adv_idx,
    output logic              any,
    output logic [CH_W-1:0]   pick
);

    logic [CH_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= (adv_idx == CH_W'(NUM_CH - 1)) ? '0 : adv_idx + 1'b1;
    end

    // Walk offsets from far to near so the nearest requester wins.
    always_comb begin
        int pos;
        any  = |req;
        pick = ptr;
        pos  = 0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            pos = int'(ptr) + k;
            if (pos >= NUM_CH)
                pos = pos - NUM_CH;
            if (req[pos])
                pick = CH_W'(pos);
        end
    end

    // R5
    pick_hits_req_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> req[pick]);

endmodule

// File: rtl/port_stats.sv
module port_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    output logic [CNT_W-1:0] busy_cnt,
    output logic [CNT_W-1:0] idle_cnt
);

    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            idle_cnt <= '0;
        end else if (active) begin
            if (busy_cnt != TOP)
                busy_cnt <= busy_cnt + 1'b1;
        end else begin
            if (idle_cnt != TOP)
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R10
    busy_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && busy_cnt != TOP) |=> busy_cnt == $past(busy_cnt) + 1'b1);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(idle_cnt));

endmodule

// File: rtl/burst_req_arbiter.sv
module burst_req_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_CH    = 5,
    parameter int ADDR_W    = 32,
    parameter int BURST_LEN = 16,
    parameter int CNT_W     = 32,
    localparam int CH_W     = idx_w(NUM_CH),
    localparam int LEN_W    = $clog2(BURST_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        rd_req,
    input  logic [NUM_CH*ADDR_W-1:0] rd_addr,
    input  logic [NUM_CH-1:0]        wr_req,
    input  logic [NUM_CH*ADDR_W-1:0] wr_addr,
    output logic [NUM_CH-1:0]        rd_gnt,
    output logic [NUM_CH-1:0]        wr_gnt,
    output logic                     cmd_valid,
    input  logic                     cmd_ready,
    output logic                     cmd_write,
    output logic [CH_W-1:0]          cmd_chan,
    output logic [ADDR_W-1:0]        cmd_addr,
    output logic [LEN_W-1:0]         cmd_len,
    output logic [CNT_W-1:0]         busy_cnt,
    output logic [CNT_W-1:0]         idle_cnt
);

    typedef struct packed {
        dir_e              dir;
        logic [CH_W-1:0]   chan;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    cmd_t            cmd_q;
    dir_e            last_dir;
    dir_e            nxt_dir;
    logic            hs;
    logic            load;
    logic            rd_any, wr_any;
    logic [CH_W-1:0] rd_pick, wr_pick;

    assign hs = cmd_valid && cmd_ready;

    rr_picker #(.NUM_CH(NUM_CH)) u_rd_pick (
        .clk     (clk),
        .rst     (rst),
        .req     (rd_req),
        .adv     (hs && cmd_q.dir == DIR_RD),
        .adv_idx (cmd_q.chan),
        .any     (rd_any),
        .pick    (rd_pick)
    );

    rr_picker #(.NUM_CH(NUM_CH)) u_wr_pick (
        .clk     (clk),
        .rst     (rst),
        .req     (wr_req),
        .adv     (hs && cmd_q.dir == DIR_WR),
        .adv_idx (cmd_q.chan),
        .any     (wr_any),
        .pick    (wr_pick)
    );

    assign nxt_dir = pick_dir(rd_any, wr_any, last_dir);
    assign load    = !cmd_valid && (rd_any || wr_any);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_q     <= '0;
            last_dir  <= DIR_WR;
        end else if (hs) begin
            cmd_valid <= 1'b0;
            last_dir  <= cmd_q.dir;
        end else if (load) begin
            cmd_valid <= 1'b1;
            cmd_q.dir <= nxt_dir;
            if (nxt_dir == DIR_WR) begin
                cmd_q.chan <= wr_pick;
                cmd_q.addr <= wr_addr[wr_pick*ADDR_W +: ADDR_W];
            end else begin
                cmd_q.chan <= rd_pick;
                cmd_q.addr <= rd_addr[rd_pick*ADDR_W +: ADDR_W];
            end
        end
    end

    assign cmd_write = (cmd_q.dir == DIR_WR);
    assign cmd_chan  = cmd_q.chan;
    assign cmd_addr  = cmd_q.addr;
    assign cmd_len   = LEN_W'(BURST_LEN);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_gnt
        assign rd_gnt[g] = hs && (cmd_q.dir == DIR_RD) && (cmd_q.chan == CH_W'(g));
        assign wr_gnt[g] = hs && (cmd_q.dir == DIR_WR) && (cmd_q.chan == CH_W'(g));
    end

    port_stats #(.CNT_W(CNT_W)) u_stats (
        .clk      (clk),
        .rst      (rst),
        .active   (cmd_valid),
        .busy_cnt (busy_cnt),
        .idle_cnt (idle_cnt)
    );

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_addr)
                                      && $stable(cmd_chan) && $stable(cmd_write));

    // R4
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_gnt, wr_gnt}));

    // R4
    gnt_req_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd_gnt & ~rd_req) | (wr_gnt & ~wr_req)) == '0);

    // R9
    cmd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

endmodule

// File: tb/test_burst_req_arbiter.sv
module test_burst_req_arbiter;

    localparam int NCH   = 5;
    localparam int AW    = 16;
    localparam int BL    = 8;
    localparam int CW    = 6;
    localparam int CHW   = 3;
    localparam int LW    = 4;
    localparam int SAT   = 63;
    localparam int NVEC  = 6;

    // {read mask, write mask, ready pattern}
    localparam logic [17:0] VEC [NVEC] = '{
        {5'b10101, 5'b00000, 8'hFF},
        {5'b00000, 5'b11111, 8'hFF},
        {5'b11111, 5'b11111, 8'hFF},
        {5'b01010, 5'b10001, 8'b10010110},
        {5'b10000, 5'b00001, 8'b00000001},
        {5'b00011, 5'b11000, 8'b11011011}
    };

    logic              clk = 0;
    logic              rst = 1;
    logic [NCH-1:0]    rd_req = '0, wr_req = '0;
    logic [NCH*AW-1:0] rd_addr, wr_addr;
    logic [NCH-1:0]    rd_gnt, wr_gnt;
    logic              cmd_valid, cmd_write;
    logic              cmd_ready = 1'b1;
    logic [CHW-1:0]    cmd_chan;
    logic [AW-1:0]     cmd_addr;
    logic [LW-1:0]     cmd_len;
    logic [CW-1:0]     busy_cnt, idle_cnt;

    burst_req_arbiter #(.NUM_CH(NCH), .ADDR_W(AW), .BURST_LEN(BL), .CNT_W(CW)) i_burst_req_arbiter (
        .clk(clk), .rst(rst),
        .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr),
        .rd_gnt(rd_gnt), .wr_gnt(wr_gnt),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_chan(cmd_chan), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .busy_cnt(busy_cnt), .idle_cnt(idle_cnt)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [NCH-1:0] rd_pend = '0, wr_pend = '0;
    logic [7:0] rdy_pat = 8'hFF;
    int cyc = 0;
    int m_rd_ptr, m_wr_ptr, exp_busy, exp_idle;
    bit m_last_wr, prev_hs, prev_idle_pend, prev_stall, first_cmd;
    logic [AW-1:0] sv_addr;
    logic [CHW-1:0] sv_chan;
    logic sv_wr;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int first_from(input logic [NCH-1:0] m, input int ptr);
        for (int k = 0; k < NCH; k++) begin
            if (m[(ptr + k) % NCH]) return (ptr + k) % NCH;
        end
        return 0;
    endfunction

    function automatic logic [AW-1:0] base_addr(input bit wr, input int ch);
        return (wr ? 16'h8000 : 16'h1000) + AW'(ch * 16);
    endfunction

    task automatic model_reset();
        m_rd_ptr = 0; m_wr_ptr = 0; m_last_wr = 1;
        exp_busy = 0; exp_idle = 0;
        prev_hs = 0; prev_idle_pend = 0; prev_stall = 0; first_cmd = 1;
    endtask

    task automatic step();
        bit hs, both, ewr;
        int ech;
        @(negedge clk);
        hs = cmd_valid && cmd_ready;
        if (prev_hs) check(!cmd_valid, "R9", "valid after handshake", cmd_valid, 0);
        if (prev_idle_pend) check(cmd_valid, "R9", "valid after idle with pending", cmd_valid, 1);
        if (prev_stall) begin
            check(cmd_valid, "R3", "valid held", cmd_valid, 1);
            check(cmd_addr == sv_addr && cmd_chan == sv_chan && cmd_write == sv_wr,
                  "R3", "addr held", int'(cmd_addr), int'(sv_addr));
        end
        if (hs) begin
            both = (rd_pend != 0) && (wr_pend != 0);
            ewr  = both ? !m_last_wr : (wr_pend != 0);
            ech  = ewr ? first_from(wr_pend, m_wr_ptr) : first_from(rd_pend, m_rd_ptr);
            check(cmd_write == ewr, both ? "R7" : "R8", "direction", cmd_write, ewr);
            check(int'(cmd_chan) == ech, ewr ? "R6" : "R5", "channel", cmd_chan, ech);
            check(cmd_addr == base_addr(ewr, ech), "R2", "address", cmd_addr, base_addr(ewr, ech));
            check(cmd_len == BL, "R2", "length", cmd_len, BL);
            check(rd_gnt == (ewr ? 5'd0 : 5'd1 << ech), "R4", "rd_gnt", rd_gnt, ewr ? 0 : 1 << ech);
            check(wr_gnt == (ewr ? 5'd1 << ech : 5'd0), "R4", "wr_gnt", wr_gnt, ewr ? 1 << ech : 0);
            if (first_cmd) check(!cmd_write && cmd_chan == 0, "R11", "first command", cmd_chan, 0);
            first_cmd = 0;
            if (ewr) m_wr_ptr = (ech + 1) % NCH; else m_rd_ptr = (ech + 1) % NCH;
            m_last_wr = ewr;
        end else begin
            check(rd_gnt == 0 && wr_gnt == 0, "R4", "grant without handshake", rd_gnt | wr_gnt, 0);
        end
        if (cmd_valid) begin if (exp_busy < SAT) exp_busy++; end
        else begin if (exp_idle < SAT) exp_idle++; end
        prev_hs = hs;
        prev_idle_pend = !cmd_valid && ((rd_pend | wr_pend) != 0);
        prev_stall = cmd_valid && !cmd_ready;
        sv_addr = cmd_addr; sv_chan = cmd_chan; sv_wr = cmd_write;
        @(posedge clk); #1;
        if (hs) begin
            if (ewr) wr_pend[ech] = 1'b0; else rd_pend[ech] = 1'b0;
        end
        rd_req = rd_pend; wr_req = wr_pend;
        cyc++;
        cmd_ready = rdy_pat[cyc % 8];
    endtask

    task automatic drain();
        int n = 0;
        while (((rd_pend | wr_pend) != 0) && n < 300) begin step(); n++; end
        step(); step();
        check(int'(busy_cnt) == exp_busy, "R10", "busy count", busy_cnt, exp_busy);
        check(int'(idle_cnt) == exp_idle, "R10", "idle count", idle_cnt, exp_idle);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            rd_addr[i*AW +: AW] = base_addr(0, i);
            wr_addr[i*AW +: AW] = base_addr(1, i);
        end
        // R1: requests during reset are not acted upon
        rst = 1; rd_pend = '1; wr_pend = '1;
        rd_req = rd_pend; wr_req = wr_pend;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!cmd_valid, "R1", "valid in reset", cmd_valid, 0);
        check(rd_gnt == 0 && wr_gnt == 0, "R1", "grants in reset", rd_gnt | wr_gnt, 0);
        check(busy_cnt == 0 && idle_cnt == 0, "R1", "counters in reset", busy_cnt + idle_cnt, 0);
        @(posedge clk); #1;
        rst = 0;
        model_reset();
        @(negedge clk);
        check(!cmd_valid, "R1", "valid first cycle", cmd_valid, 0);
        check(busy_cnt == 0 && idle_cnt == 0, "R1", "counters first cycle", busy_cnt + idle_cnt, 0);
        if (exp_idle < SAT) exp_idle++;
        prev_idle_pend = 1;
        @(posedge clk); #1;
        // R11: all channels of both directions pending straight out of reset
        drain();
        // vector table
        for (int v = 0; v < NVEC; v++) begin
            rd_pend = VEC[v][17:13];
            wr_pend = VEC[v][12:8];
            rdy_pat = VEC[v][7:0];
            rd_req = rd_pend; wr_req = wr_pend;
            cmd_ready = rdy_pat[cyc % 8];
            drain();
        end
        // idle stretch to reach R10 saturation
        rdy_pat = 8'hFF; cmd_ready = 1'b1;
        repeat (80) step();
        check(int'(idle_cnt) == exp_idle, "R10", "idle saturation", idle_cnt, exp_idle);
        check(int'(busy_cnt) == exp_busy, "R10", "busy final", busy_cnt, exp_busy);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule